// File: doc/BRIEF.md
# Front Panel Examine and Deposit Sequencer

This block lets a toggle-switch front panel take charge of an 8-bit processor. It holds a run/stop flip-flop and drives the processor's ready line. When the processor is halted, the operator can ask it to examine a location, examine the next location, deposit a byte, deposit into the next location, or single-step. For each request the block runs a short sequence. The sequence forces bytes onto the processor data bus, so the processor itself loads the address or moves it forward. The block can also raise a memory-write request that stores the data switches at the current address.

Examine forces three bytes, one per instruction fetch: a jump opcode (0xC3), then address switches 7:0, then address switches 15:8. After that it drops ready for one cycle so the processor halts at the new address. Examine-next forces a single no-operation byte (0x00), so the address moves forward by one. A two-bit phase counter steps on the instruction-fetch status strobe and walks through these states. A small mode register records which request is being served.

Top module: `fp_jam_seq`

## Requirements
- R1: During and right after power-on reset (`rst_n` low), `run_on`, `proc_rdy`, `bus_oe` and `mem_wr` are all 0.
- R2: A `run_req` pulse sets `run_on` and `proc_rdy` to 1 on the next cycle. A `stop_req` pulse clears them. If both arrive in the same cycle, stop wins.
- R3: `panel_rst` returns any active sequence to idle on the next cycle. If `stop_req` is held at the same time, the block is left halted: `run_on`=0 and `proc_rdy`=0.
- R4: One cycle after an accepted `exam_req`, `bus_oe`=1, `bus_dout`=0xC3 and `proc_rdy`=1. The byte is held until `fetch_stb` is seen.
- R5: Examine steps through exactly four phases, moving on each `fetch_stb`. The phases are 0xC3, then `addr_sw[7:0]`, then `addr_sw[15:8]`, then one cycle with `proc_rdy`=0 and `bus_oe`=0. The block is idle on the cycle after that.
- R6: Examine-next drives `bus_dout`=0x00 with `proc_rdy`=1 until one `fetch_stb`. It then halts for one cycle and returns to idle. It never drives 0xC3 or address bytes.
- R7: Deposit gives one cycle with `mem_wr`=1, `bus_oe`=1, `bus_dout`=`data_sw` and `proc_rdy`=1. This is followed by one halt cycle, then idle.
- R8: Deposit-next first drives 0x00 until one `fetch_stb`, with `mem_wr`=0. The next cycle is the deposit cycle of R7.
- R9: Single-step holds `proc_rdy`=1 with `bus_oe`=0 until one `fetch_stb`. It then halts for one cycle.
- R10: Front-panel sequence requests are ignored while `run_on`=1 and while a sequence is active.
- R11: When several requests arrive together, the priority is examine, then examine-next, then deposit, then deposit-next, then step.
- R12: When idle and not running, `proc_rdy`=0, `bus_oe`=0, `bus_dout`=0x00 and `mem_wr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| run_req | input | 1 | Debounced RUN pulse |
| stop_req | input | 1 | Debounced STOP pulse or level |
| panel_rst | input | 1 | Debounced front-panel RESET pulse |
| exam_req | input | 1 | EXAMINE pulse |
| exnx_req | input | 1 | EXAMINE NEXT pulse |
| dep_req | input | 1 | DEPOSIT pulse |
| dpnx_req | input | 1 | DEPOSIT NEXT pulse |
| step_req | input | 1 | Single-step pulse |
| addr_sw | input | 16 | Address switches |
| data_sw | input | 8 | Data switches |
| fetch_stb | input | 1 | Instruction-fetch status strobe |
| bus_dout | output | 8 | Byte forced onto the processor data bus |
| bus_oe | output | 1 | Enable for the forced byte |
| mem_wr | output | 1 | Memory-write request |
| proc_rdy | output | 1 | Processor ready |
| run_on | output | 1 | Run/stop flip-flop state |

## Verification
Every output is decoded without further registers from the mode, phase and run flip-flops. So each response is due exactly one clock edge after the request or fetch strobe that causes it. Halt cycles and the return to idle follow at one more edge each. The bench changes inputs and samples outputs a short time after each rising edge. It checks the forced byte on the first cycle after an accepted request, and checks it again after each strobe edge. Holding cycles without a strobe confirm that the byte stays put. Deposits are swept over all 256 data values and examines over a spread of addresses.

// File: rtl/fp_jam_seq.sv
module fp_jam_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [7:0] JMP_OP = 8'hC3,
  parameter logic [7:0] NOP_OP = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_req,
  input  logic          stop_req,
  input  logic          panel_rst,
  input  logic          exam_req,
  input  logic          exnx_req,
  input  logic          dep_req,
  input  logic          dpnx_req,
  input  logic          step_req,
  input  logic [AW-1:0] addr_sw,
  input  logic [DW-1:0] data_sw,
  input  logic          fetch_stb,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          mem_wr,
  output logic          proc_rdy,
  output logic          run_on
);
  localparam logic [2:0] M_IDLE = 3'd0, M_EXAM = 3'd1, M_EXNX = 3'd2,
                         M_DEP  = 3'd3, M_DPNX = 3'd4, M_STEP = 3'd5;
  localparam logic [1:0] PH_HALT = 2'd3;

  logic [2:0] mode_q, mode_d;
  logic [1:0] ph_q, ph_d;
  logic       run_q;

  wire busy = (mode_q != M_IDLE);
  wire ph0  = (ph_q == 2'd0);

  always_comb begin
    mode_d = mode_q;
    ph_d   = ph_q;
    if (panel_rst) begin
      mode_d = M_IDLE;
      ph_d   = 2'd0;
    end else if (!busy) begin
      ph_d = 2'd0;
      if (!run_q) begin
        if (exam_req)      mode_d = M_EXAM;
        else if (exnx_req) mode_d = M_EXNX;
        else if (dep_req)  mode_d = M_DEP;
        else if (dpnx_req) mode_d = M_DPNX;
        else if (step_req) mode_d = M_STEP;
      end
    end else if (ph_q == PH_HALT) begin
      mode_d = M_IDLE;
      ph_d   = 2'd0;
    end else begin
      case (mode_q)
        M_EXAM:         if (fetch_stb) ph_d = ph_q + 2'd1;
        M_EXNX, M_STEP: if (fetch_stb) ph_d = PH_HALT;
        M_DPNX:         if (fetch_stb) mode_d = M_DEP;
        M_DEP:          ph_d = PH_HALT;
        default: begin
          mode_d = M_IDLE;
          ph_d   = 2'd0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      ph_q   <= 2'd0;
      run_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ph_q   <= ph_d;
      if (stop_req)     run_q <= 1'b0;
      else if (run_req) run_q <= 1'b1;
    end
  end

  always_comb begin
    bus_dout = '0;
    bus_oe   = 1'b0;
    case (mode_q)
      M_EXAM: begin
        bus_oe = (ph_q != PH_HALT);
        case (ph_q)
          2'd0:    bus_dout = JMP_OP;
          2'd1:    bus_dout = addr_sw[DW-1:0];
          2'd2:    bus_dout = addr_sw[2*DW-1:DW];
          default: bus_dout = '0;
        endcase
      end
      M_EXNX, M_DPNX: begin
        bus_oe   = ph0;
        bus_dout = ph0 ? NOP_OP : '0;
      end
      M_DEP: begin
        bus_oe   = ph0;
        bus_dout = ph0 ? data_sw : '0;
      end
      default: ;
    endcase
  end

  assign mem_wr   = (mode_q == M_DEP) && ph0;
  assign proc_rdy = run_q || (busy && ph_q != PH_HALT);
  assign run_on   = run_q;
endmodule

// File: rtl/fp_jam_seq_chk.sv
module fp_jam_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_req,
  input logic       panel_rst,
  input logic       fetch_stb,
  input logic       run_on,
  input logic       proc_rdy,
  input logic       bus_oe,
  input logic       mem_wr,
  input logic [7:0] bus_dout,
  input logic [7:0] data_sw,
  input logic [2:0] mode,
  input logic [1:0] ph
);
  // R2
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !run_on && !proc_rdy);
  // R7
  dep_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> bus_oe && bus_dout == data_sw && proc_rdy);
  // R5
  exam_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && ph != 2'd3 && fetch_stb && !panel_rst)
      |=> mode == 3'd1 && ph == $past(ph) + 2'd1);
  // R5
  halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd0 && ph == 2'd3) |=> mode == 3'd0);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_on && mode == 3'd0) |-> !proc_rdy && !bus_oe && !mem_wr);
  // R3
  panel_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    panel_rst |=> mode == 3'd0);
endmodule

bind fp_jam_seq fp_jam_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .panel_rst(panel_rst),
  .fetch_stb(fetch_stb), .run_on(run_on), .proc_rdy(proc_rdy),
  .bus_oe(bus_oe), .mem_wr(mem_wr), .bus_dout(bus_dout), .data_sw(data_sw),
  .mode(mode_q), .ph(ph_q)
);

// File: tb/fp_jam_seq_tb.sv
module fp_jam_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run_req = 0, stop_req = 0, panel_rst = 0, exam_req = 0, exnx_req = 0;
  logic dep_req = 0, dpnx_req = 0, step_req = 0, fetch_stb = 0;
  logic [15:0] addr_sw = '0;
  logic [7:0]  data_sw = '0;
  logic [7:0]  bus_dout;
  logic bus_oe, mem_wr, proc_rdy, run_on;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fp_jam_seq dut_i (.*);

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet(string req);
    chk(req, {proc_rdy, bus_oe, mem_wr, bus_dout}, 32'h0);
  endtask

  task automatic strobe;
    fetch_stb = 1; tick(); fetch_stb = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1", {run_on, proc_rdy, bus_oe, mem_wr}, 0);
    rst_n = 1; tick(2);
    chk("R1", {run_on, proc_rdy, bus_oe, mem_wr}, 0);
    quiet("R12");

    run_req = 1; tick(); run_req = 0;
    chk("R2", {run_on, proc_rdy}, 2'b11);
    exam_req = 1; tick(); exam_req = 0;
    chk("R10", {bus_oe, mem_wr}, 0);
    stop_req = 1; tick(); stop_req = 0;
    chk("R2", {run_on, proc_rdy}, 0);
    quiet("R10");
    run_req = 1; stop_req = 1; tick(); run_req = 0; stop_req = 0;
    chk("R2", run_on, 0);

    run_req = 1; tick(); run_req = 0;
    panel_rst = 1; stop_req = 1; tick(); panel_rst = 0; stop_req = 0;
    chk("R3", {run_on, proc_rdy}, 0);
    addr_sw = 16'h1234; exam_req = 1; tick(); exam_req = 0;
    strobe();
    chk("R5", bus_dout, 8'h34);
    panel_rst = 1; tick(); panel_rst = 0;
    quiet("R3");

    for (int i = 0; i < 32; i++) begin
      addr_sw = 16'(i * 16'h0811) ^ 16'hA5C3;
      exam_req = 1; tick(); exam_req = 0;
      chk("R4", {bus_oe, proc_rdy, bus_dout}, {2'b11, 8'hC3});
      tick(i % 3);
      chk("R4", bus_dout, 8'hC3);
      strobe();
      chk("R5", {bus_oe, bus_dout}, {1'b1, addr_sw[7:0]});
      if (i == 5) begin
        dep_req = 1; tick(); dep_req = 0;
        chk("R10", {mem_wr, bus_dout}, {1'b0, addr_sw[7:0]});
      end
      strobe();
      chk("R5", {bus_oe, bus_dout}, {1'b1, addr_sw[15:8]});
      strobe();
      chk("R5", {proc_rdy, bus_oe}, 0);
      tick();
      quiet("R5");
    end

    exnx_req = 1; tick(); exnx_req = 0;
    chk("R6", {proc_rdy, bus_oe, mem_wr, bus_dout}, {3'b110, 8'h00});
    tick(2);
    chk("R6", {proc_rdy, bus_oe, bus_dout}, {2'b11, 8'h00});
    strobe();
    chk("R6", {proc_rdy, bus_oe}, 0);
    tick();
    quiet("R6");

    for (int v = 0; v < 256; v++) begin
      data_sw = 8'(v);
      dep_req = 1; tick(); dep_req = 0;
      chk("R7", {mem_wr, bus_oe, proc_rdy, bus_dout}, {3'b111, data_sw});
      tick();
      chk("R7", {proc_rdy, mem_wr, bus_oe}, 0);
      tick();
      quiet("R7");
    end

    data_sw = 8'h5A;
    dpnx_req = 1; tick(); dpnx_req = 0;
    chk("R8", {mem_wr, bus_oe, proc_rdy, bus_dout}, {3'b011, 8'h00});
    tick();
    chk("R8", mem_wr, 0);
    strobe();
    chk("R8", {mem_wr, bus_oe, bus_dout}, {2'b11, 8'h5A});
    tick(2);
    quiet("R8");

    step_req = 1; tick(); step_req = 0;
    chk("R9", {proc_rdy, bus_oe, mem_wr}, 3'b100);
    tick(3);
    chk("R9", proc_rdy, 1);
    strobe();
    chk("R9", proc_rdy, 0);
    tick();
    quiet("R9");

    exam_req = 1; dep_req = 1; step_req = 1; tick();
    exam_req = 0; dep_req = 0; step_req = 0;
    chk("R11", {mem_wr, bus_dout}, {1'b0, 8'hC3});
    panel_rst = 1; tick(); panel_rst = 0;
    exnx_req = 1; dep_req = 1; tick(); exnx_req = 0; dep_req = 0;
    chk("R11", {mem_wr, bus_oe, bus_dout}, {2'b01, 8'h00});
    panel_rst = 1; tick(); panel_rst = 0;
    dep_req = 1; dpnx_req = 1; step_req = 1; tick();
    dep_req = 0; dpnx_req = 0; step_req = 0;
    chk("R11", {mem_wr, bus_dout}, {1'b1, 8'h5A});
    tick(2);
    dpnx_req = 1; step_req = 1; tick(); dpnx_req = 0; step_req = 0;
    chk("R11", {bus_oe, bus_dout}, {1'b1, 8'h00});
    panel_rst = 1; tick(); panel_rst = 0;
    quiet("R12");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule